// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block sits between a flash controller's retry policy and its raw NAND bus engine. A single start pulse launches one of two jobs. The apply job moves the flash into a chosen read-retry mode. It brackets a burst of private parameter-register writes between an enter opcode and an apply opcode, and it takes each written value from a mode-indexed parameter table. The fetch job reads the factory page that holds those parameters. It sets up a private register, unlocks the page with a fixed opcode chain, reads the page, and then returns the flash to normal operation.

Each bus action is issued as a primitive: reset, command byte, column address, data byte, or page read. Every primitive is offered with a valid/ready handshake. The sequencer then waits for the engine's completion strobe before it moves on. A completion that reports an error ends the job at once, and the done pulse then carries the error flag.

Top module: `nand_rr_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and prim_valid_o are all low.
- R2: An apply job (op_i=0) issues exactly 2*NREGS+2 primitives in this order: command 0x36, then a column address and a data byte for each parameter register, then command 0x16. Kind codes are 0 reset, 1 command, 2 column address, 3 data byte and 4 page read. A command or data byte travels in prim_arg_o[7:0] with the upper byte zero.
- R3: The column address for register i carries that register's address in both bytes of prim_arg_o. Registers are visited in the order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R4: The data byte for register i in mode m is the table entry at tbl_addr_o = m*NREGS + i.
- R5: A fetch job (op_i=1) starts with these primitives: reset, command 0x36, column 0x3838, data 0x52, command 0x16, command 0x17, command 0x04, command 0x19.
- R6: The ninth primitive of a fetch job is a page read. With variant_i=0 it targets page 0x21F with length 784. With variant_i=1 it targets page 0x200 with length 528. The page goes in prim_arg_o and the length in prim_len_o.
- R7: After the page read, a fetch job issues reset, command 0x36, column 0x3838, data 0x00 and command 0x16. It ends with a page read of page 0 and length 0, which makes 15 primitives in all.
- R8: A completion with cpl_err_i high stops the job. No further primitive is offered, and the done pulse follows with err_o high.
- R9: busy_o rises the cycle after an accepted start and stays high until the cycle in which done_o pulses for one cycle. err_o is high only together with done_o.
- R10: start_i has no effect while busy_o is high. The running job continues unchanged.
- R11: prim_valid_o holds with a stable kind, argument and length until prim_ready_i is seen. No new primitive is offered until the accepted one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a job |
| op_i | input | 1 | 0 = apply mode, 1 = fetch parameter page |
| mode_i | input | MODE_W | Retry mode index for the apply job |
| variant_i | input | 1 | Selects the alternate page/length for the fetch job |
| tbl_addr_o | output | TBL_AW | Parameter table read address |
| tbl_data_i | input | 8 | Parameter table read data (combinational) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion pulse |
| err_o | output | 1 | Job ended on an error (valid with done_o) |
| prim_valid_o | output | 1 | Primitive request valid |
| prim_ready_i | input | 1 | Bus engine accepts the request |
| prim_kind_o | output | 3 | Primitive kind code |
| prim_arg_o | output | 16 | Opcode, column, data byte or page address |
| prim_len_o | output | 16 | Page read length in bytes |
| cpl_i | input | 1 | Completion strobe for the accepted primitive |
| cpl_err_i | input | 1 | Completion reports failure |

## Verification
The bound checker checks the following on every cycle. A pending request holds its payload until it is accepted. Every request falls inside a busy window. done_o is a single-cycle pulse that coincides with busy falling. A failing completion is followed at once by done with err_o and no new request. Only the bench's scenarios can show the exact primitive order and values for apply and fetch jobs, the table indexing across modes, the page-read variants, that a start during a job is ignored, and aborts at different points in each job. The bench checks these against a queue of expected primitives that it builds from the requirements.

// File: rtl/nand_rr_pkg.sv
package nand_rr_pkg;

  typedef enum logic [2:0] {
    PK_RESET = 3'd0,
    PK_CMD   = 3'd1,
    PK_COL   = 3'd2,
    PK_WDATA = 3'd3,
    PK_READ  = 3'd4
  } prim_kind_e;

  localparam logic [7:0] OPC_ENTER = 8'h36;
  localparam logic [7:0] OPC_APPLY = 8'h16;
  localparam logic [7:0] OPC_UNL0  = 8'h17;
  localparam logic [7:0] OPC_UNL1  = 8'h04;
  localparam logic [7:0] OPC_UNL2  = 8'h19;
  localparam logic [7:0] GATE_REG  = 8'h38;
  localparam logic [7:0] GATE_KEY  = 8'h52;

  localparam int FETCH_STEPS = 15;

  // parameter register address by visit order
  function automatic logic [7:0] param_reg(logic [2:0] idx);
    case (idx)
      3'd0:    return 8'hCC;
      3'd1:    return 8'hBF;
      3'd2:    return 8'hAA;
      3'd3:    return 8'hAB;
      3'd4:    return 8'hCD;
      3'd5:    return 8'hAD;
      3'd6:    return 8'hAE;
      default: return 8'hAF;
    endcase
  endfunction

endpackage

// File: rtl/nand_rr_step_gen.sv
module nand_rr_step_gen
  import nand_rr_pkg::*;
#(
  parameter int          NREGS     = 8,
  parameter int          MODE_W    = 3,
  parameter int          TBL_AW    = 6,
  parameter int          STEP_W    = 5,
  parameter logic [15:0] PAGE_MAIN = 16'h021F,
  parameter logic [15:0] LEN_MAIN  = 16'd784,
  parameter logic [15:0] PAGE_ALT  = 16'h0200,
  parameter logic [15:0] LEN_ALT   = 16'd528
) (
  input  logic              op_fetch_i,
  input  logic              alt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [7:0]        tbl_data_i,
  output prim_kind_e        kind_o,
  output logic [15:0]       arg_o,
  output logic [15:0]       len_o,
  output logic [TBL_AW-1:0] tbl_addr_o,
  output logic              last_o
);

  localparam int APPLY_LAST = 2 * NREGS + 1;

  logic [STEP_W-1:0] j;
  logic [STEP_W-2:0] ridx;
  logic [7:0]        reg_addr;

  assign j          = step_i - STEP_W'(1);
  assign ridx       = j[STEP_W-1:1];
  assign reg_addr   = param_reg(ridx[2:0]);
  assign tbl_addr_o = TBL_AW'(mode_i) * TBL_AW'(NREGS) + TBL_AW'(ridx);

  always_comb begin
    kind_o = PK_CMD;
    arg_o  = '0;
    len_o  = '0;
    last_o = 1'b0;
    if (!op_fetch_i) begin
      if (step_i == '0) begin
        arg_o = {8'h00, OPC_ENTER};
      end else if (step_i == STEP_W'(APPLY_LAST)) begin
        arg_o  = {8'h00, OPC_APPLY};
        last_o = 1'b1;
      end else if (!j[0]) begin
        kind_o = PK_COL;
        arg_o  = {reg_addr, reg_addr};
      end else begin
        kind_o = PK_WDATA;
        arg_o  = {8'h00, tbl_data_i};
      end
    end else begin
      case (step_i)
        STEP_W'(0), STEP_W'(9): kind_o = PK_RESET;
        STEP_W'(1), STEP_W'(10): arg_o = {8'h00, OPC_ENTER};
        STEP_W'(2), STEP_W'(11): begin
          kind_o = PK_COL;
          arg_o  = {GATE_REG, GATE_REG};
        end
        STEP_W'(3): begin
          kind_o = PK_WDATA;
          arg_o  = {8'h00, GATE_KEY};
        end
        STEP_W'(12): kind_o = PK_WDATA;
        STEP_W'(4), STEP_W'(13): arg_o = {8'h00, OPC_APPLY};
        STEP_W'(5): arg_o = {8'h00, OPC_UNL0};
        STEP_W'(6): arg_o = {8'h00, OPC_UNL1};
        STEP_W'(7): arg_o = {8'h00, OPC_UNL2};
        STEP_W'(8): begin
          kind_o = PK_READ;
          arg_o  = alt_i ? PAGE_ALT : PAGE_MAIN;
          len_o  = alt_i ? LEN_ALT : LEN_MAIN;
        end
        default: begin
          kind_o = PK_READ;
          last_o = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/nand_rr_prim_port.sv
module nand_rr_prim_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic ready_i,
  input  logic cpl_i,
  input  logic cpl_err_i,
  output logic valid_o,
  output logic idle_o,
  output logic step_done_o,
  output logic step_err_o
);

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} port_st_e;
  port_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      P_IDLE:  if (launch_i) st_d = P_REQ;
      P_REQ:   if (ready_i) st_d = P_WAIT;
      P_WAIT:  if (cpl_i) st_d = P_IDLE;
      default: st_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= P_IDLE;
    else         st_q <= st_d;
  end

  assign valid_o     = (st_q == P_REQ);
  assign idle_o      = (st_q == P_IDLE);
  assign step_done_o = (st_q == P_WAIT) && cpl_i;
  assign step_err_o  = step_done_o && cpl_err_i;

endmodule

// File: rtl/nand_rr_seq.sv
module nand_rr_seq
  import nand_rr_pkg::*;
#(
  parameter int          NREGS     = 8,
  parameter int          NMODES    = 8,
  parameter logic [15:0] PAGE_MAIN = 16'h021F,
  parameter logic [15:0] LEN_MAIN  = 16'd784,
  parameter logic [15:0] PAGE_ALT  = 16'h0200,
  parameter logic [15:0] LEN_ALT   = 16'd528,
  localparam int MODE_W      = (NMODES > 1) ? $clog2(NMODES) : 1,
  localparam int TBL_AW      = (NREGS * NMODES > 1) ? $clog2(NREGS * NMODES) : 1,
  localparam int APPLY_STEPS = 2 * NREGS + 2,
  localparam int MAX_STEPS   = (APPLY_STEPS > FETCH_STEPS) ? APPLY_STEPS : FETCH_STEPS,
  localparam int STEP_W      = $clog2(MAX_STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              variant_i,
  output logic [TBL_AW-1:0] tbl_addr_o,
  input  logic [7:0]        tbl_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              prim_valid_o,
  input  logic              prim_ready_i,
  output logic [2:0]        prim_kind_o,
  output logic [15:0]       prim_arg_o,
  output logic [15:0]       prim_len_o,
  input  logic              cpl_i,
  input  logic              cpl_err_i
);

  typedef enum logic {S_IDLE, S_RUN} seq_st_e;

  seq_st_e           st_q;
  logic              op_q, alt_q, done_q, err_q;
  logic [MODE_W-1:0] mode_q;
  logic [STEP_W-1:0] step_q;
  logic              port_idle, step_done, step_err, last_step, launch;
  prim_kind_e        kind;

  nand_rr_step_gen #(
    .NREGS(NREGS), .MODE_W(MODE_W), .TBL_AW(TBL_AW), .STEP_W(STEP_W),
    .PAGE_MAIN(PAGE_MAIN), .LEN_MAIN(LEN_MAIN),
    .PAGE_ALT(PAGE_ALT), .LEN_ALT(LEN_ALT)
  ) u_gen (
    .op_fetch_i (op_q),
    .alt_i      (alt_q),
    .mode_i     (mode_q),
    .step_i     (step_q),
    .tbl_data_i (tbl_data_i),
    .kind_o     (kind),
    .arg_o      (prim_arg_o),
    .len_o      (prim_len_o),
    .tbl_addr_o (tbl_addr_o),
    .last_o     (last_step)
  );

  assign launch = (st_q == S_RUN) && port_idle;

  nand_rr_prim_port u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .ready_i     (prim_ready_i),
    .cpl_i       (cpl_i),
    .cpl_err_i   (cpl_err_i),
    .valid_o     (prim_valid_o),
    .idle_o      (port_idle),
    .step_done_o (step_done),
    .step_err_o  (step_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= 1'b0;
      alt_q  <= 1'b0;
      mode_q <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_RUN;
          op_q   <= op_i;
          alt_q  <= variant_i;
          mode_q <= mode_i;
          step_q <= '0;
        end
        S_RUN: if (step_done) begin
          if (step_err || last_step) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= step_err;
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q == S_RUN);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign prim_kind_o = kind;

endmodule

// File: rtl/nand_rr_seq_chk.sv
module nand_rr_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        prim_valid_o,
  input logic        prim_ready_i,
  input logic [2:0]  prim_kind_o,
  input logic [15:0] prim_arg_o,
  input logic [15:0] prim_len_o,
  input logic        cpl_i,
  input logic        cpl_err_i
);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_valid_o && !prim_ready_i |=> prim_valid_o && $stable(prim_kind_o)
      && $stable(prim_arg_o) && $stable(prim_len_o));

  // R11
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_valid_o && prim_ready_i |=> !prim_valid_o);

  // R9
  req_in_job_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_valid_o |-> busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $fell(busy_o));

  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !prim_valid_o && cpl_i && cpl_err_i |=> done_o && err_o && !prim_valid_o);

endmodule

bind nand_rr_seq nand_rr_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .prim_valid_o (prim_valid_o),
  .prim_ready_i (prim_ready_i),
  .prim_kind_o  (prim_kind_o),
  .prim_arg_o   (prim_arg_o),
  .prim_len_o   (prim_len_o),
  .cpl_i        (cpl_i),
  .cpl_err_i    (cpl_err_i)
);

// File: tb/nand_rr_seq_bench.sv
module nand_rr_seq_bench;

  localparam int NREGS  = 8;
  localparam int NMODES = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        variant_i = 1'b0;
  logic [5:0]  tbl_addr_o;
  logic [7:0]  tbl_data_i;
  logic        busy_o, done_o, err_o, prim_valid_o;
  logic        prim_ready_i = 1'b0;
  logic [2:0]  prim_kind_o;
  logic [15:0] prim_arg_o, prim_len_o;
  logic        cpl_i = 1'b0;
  logic        cpl_err_i = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  assign tbl_data_i = 8'(tbl_addr_o * 7 + 3);

  nand_rr_seq u_nand_rr_seq (.*);

  int          n_exp;
  logic [2:0]  exp_k [32];
  logic [15:0] exp_a [32];
  logic [15:0] exp_l [32];
  string       exp_t [32];

  function automatic logic [7:0] reg_at(int i);
    logic [7:0] regs [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
    return regs[i];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [15:0] a, input logic [15:0] l, input string t);
    exp_k[n_exp] = k; exp_a[n_exp] = a; exp_l[n_exp] = l; exp_t[n_exp] = t;
    n_exp++;
  endtask

  task automatic build_apply(input int m);
    n_exp = 0;
    push(3'd1, 16'h0036, 0, "R2");
    for (int i = 0; i < NREGS; i++) begin
      push(3'd2, {reg_at(i), reg_at(i)}, 0, "R3");
      push(3'd3, {8'h00, 8'((m * NREGS + i) * 7 + 3)}, 0, "R4");
    end
    push(3'd1, 16'h0016, 0, "R2");
  endtask

  task automatic build_fetch(input bit alt);
    n_exp = 0;
    push(3'd0, 0, 0, "R5");
    push(3'd1, 16'h0036, 0, "R5");
    push(3'd2, 16'h3838, 0, "R5");
    push(3'd3, 16'h0052, 0, "R5");
    push(3'd1, 16'h0016, 0, "R5");
    push(3'd1, 16'h0017, 0, "R5");
    push(3'd1, 16'h0004, 0, "R5");
    push(3'd1, 16'h0019, 0, "R5");
    push(3'd4, alt ? 16'h0200 : 16'h021F, alt ? 16'd528 : 16'd784, "R6");
    push(3'd0, 0, 0, "R7");
    push(3'd1, 16'h0036, 0, "R7");
    push(3'd2, 16'h3838, 0, "R7");
    push(3'd3, 16'h0000, 0, "R7");
    push(3'd1, 16'h0016, 0, "R7");
    push(3'd4, 0, 0, "R7");
  endtask

  // plays the bus engine against the expected queue; err_at<0 means no error
  task automatic run_job(input bit op, input int m, input bit alt, input int err_at, input bit poke);
    int last;
    if (op) build_fetch(alt); else build_apply(m);
    last = (err_at >= 0) ? err_at : n_exp - 1;
    @(negedge clk_i);
    op_i = op; mode_i = 3'(m); variant_i = alt; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    for (int s = 0; s <= last; s++) begin
      int w = 0;
      while (!prim_valid_o && w < 20) begin
        check(busy_o == 1'b1, "R9 busy held", busy_o, 1);
        if (poke && s == 3) begin
          op_i = ~op; start_i = 1'b1;
        end
        @(negedge clk_i);
        start_i = 1'b0;
        w++;
      end
      check(prim_valid_o == 1'b1, {exp_t[s], " request seen"}, prim_valid_o, 1);
      for (int h = 0; h < (s % 3); h++) begin
        @(negedge clk_i);
        check(prim_valid_o == 1'b1, "R11 valid held", prim_valid_o, 1);
      end
      check(prim_kind_o == exp_k[s], {exp_t[s], " kind"}, prim_kind_o, exp_k[s]);
      check(prim_arg_o == exp_a[s], {exp_t[s], " arg"}, prim_arg_o, exp_a[s]);
      check(prim_len_o == exp_l[s], {exp_t[s], " len"}, prim_len_o, exp_l[s]);
      prim_ready_i = 1'b1;
      @(negedge clk_i);
      prim_ready_i = 1'b0;
      for (int d = 0; d < 1 + (s % 4); d++) begin
        check(prim_valid_o == 1'b0, "R11 no request before completion", prim_valid_o, 0);
        @(negedge clk_i);
      end
      cpl_i = 1'b1;
      cpl_err_i = (s == err_at);
      @(negedge clk_i);
      cpl_i = 1'b0;
      cpl_err_i = 1'b0;
    end
    check(done_o == 1'b1, "R9 done pulse", done_o, 1);
    check(err_o == (err_at >= 0), "R8 err flag", err_o, err_at >= 0);
    check(busy_o == 1'b0, "R9 busy clear at done", busy_o, 0);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk_i);
      check(done_o == 1'b0 && err_o == 1'b0, "R9 done single cycle", done_o, 0);
      check(prim_valid_o == 1'b0, "R8 no request after end", prim_valid_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(busy_o == 0 && done_o == 0 && err_o == 0 && prim_valid_o == 0,
          "R1 reset state", {busy_o, done_o, err_o, prim_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 0 && prim_valid_o == 0, "R1 idle after reset", busy_o, 0);
    run_job(1'b0, 0, 1'b0, -1, 1'b0);
    run_job(1'b0, 5, 1'b0, -1, 1'b0);
    run_job(1'b0, 7, 1'b1, -1, 1'b1);   // R10 start ignored mid-job
    run_job(1'b1, 0, 1'b0, -1, 1'b0);
    run_job(1'b1, 0, 1'b1, -1, 1'b0);
    run_job(1'b0, 3, 1'b0, 4, 1'b0);    // R8 abort mid apply
    run_job(1'b1, 0, 1'b0, 8, 1'b0);    // R8 abort on page read
    run_job(1'b1, 0, 1'b1, 0, 1'b1);    // R8 abort on first step
    run_job(1'b0, 2, 1'b0, -1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule